// File: doc/BRIEF.md
# Lossless Socket Interrupt Controller

This block collects interrupt events from the four sockets of a small network offload engine and drives a single active-low interrupt line toward a host processor. Each socket owns five status flags. Event strobes from the protocol logic set flags. The host reads the flags and acknowledges them by writing ones to a chosen socket. A per-flag enable mask decides which flags may pull the line low.

The controller is built so that no event is lost. An event that lands in the same cycle as the host's acknowledge of that flag keeps the flag set. When the host issues a receive-complete command for a socket whose receive buffer still holds bytes, the receive flag is raised again one cycle later, after the buffer count has settled. Every acknowledge write that clears at least one flag releases the line for a programmable number of clock cycles. If an enabled flag is still set when that interval ends, the line falls again, so an edge-triggered host always sees a new falling edge.

Top module: `sock_irq_ctrl`

## Requirements
- R1: After reset every status flag reads 0 and `irq_n_o` is 1.
- R2: Socket s owns status bits 5s to 5s+4, with flag order connect (+0), disconnect (+1), receive (+2), timeout (+3), send-ok (+4). A strobe on `evt_i` bit k sets `status_o` bit k at the next clock edge, and `irq_n_o` is 0 whenever any bit of `status_o & mask_i` is 1 and no release interval is running.
- R3: If an event strobe and a host clear hit the same bit in the same cycle, that bit is 1 afterwards.
- R4: A write with `clr_we_i`=1 clears the bits of socket `clr_sel_i` where `clr_bits_i` is 1. Bits where it is 0 are left unchanged. A write whose `clr_bits_i` is all zero also starts no release interval.
- R5: One cycle after `rx_done_i[s]` is sampled high, the receive flag (bit 5s+2) of socket s is set again if the occupancy field `rx_occ_i[s*OCC_W +: OCC_W]` is nonzero. If the field is zero, the flag stays clear.
- R6: A clear write with nonzero `clr_bits_i` holds `irq_n_o` at 1 for exactly `pend_i` cycles after the edge that samples the write. A later clear write reloads the interval.
- R7: When the release interval ends, `irq_n_o` returns to 0 if any enabled flag is still set. With `pend_i`=0 there is no release.
- R8: A flag whose mask bit is 0 stays visible on `status_o` but never drives `irq_n_o` low. Setting its mask bit later lets it drive the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SOCK*5 | One-cycle event strobes, one per flag |
| clr_we_i | input | 1 | Host acknowledge write strobe |
| clr_sel_i | input | SEL_W | Socket addressed by the acknowledge write |
| clr_bits_i | input | 5 | Write-one-to-clear data for the addressed socket |
| mask_i | input | NUM_SOCK*5 | Per-flag interrupt enables |
| rx_done_i | input | NUM_SOCK | Receive-complete command strobes, one per socket |
| rx_occ_i | input | NUM_SOCK*OCC_W | Receive buffer byte count of each socket |
| pend_i | input | PEND_W | Release interval in clock cycles |
| status_o | output | NUM_SOCK*5 | Status flags |
| irq_n_o | output | 1 | Active-low interrupt to the host |

## Verification
The bench builds the block with its defaults: four sockets, an 11-bit occupancy count and a 16-bit interval register. At run time it loads a short interval of 6 cycles, so the whole release and fall-again sequence can be checked cycle by cycle, and a zero interval to cover the no-release case. Using four sockets reaches the top socket slice and the socket-select decode, and the receive re-check runs with both a nonzero and an empty buffer count.

// File: rtl/sock_irq_pkg.sv
package sock_irq_pkg;
  localparam int FLAG_W    = 5;
  localparam int F_CONN    = 0;
  localparam int F_DISC    = 1;
  localparam int F_RECV    = 2;
  localparam int F_TMO     = 3;
  localparam int F_SENDOK  = 4;

  typedef logic [FLAG_W-1:0] flags_t;

  // Write-one-to-clear merge; set sources win over a clear.
  function automatic flags_t flag_merge(input flags_t cur, input flags_t set_v,
                                        input flags_t clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  // Receive re-raise as a flag vector.
  function automatic flags_t recv_only(input logic hit);
    flags_t v;
    v = '0;
    v[F_RECV] = hit;
    return v;
  endfunction
endpackage

// File: rtl/sock_irq_status.sv
module sock_irq_status
  import sock_irq_pkg::*;
#(
  parameter int NUM_SOCK = 4,
  parameter int SEL_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SOCK*FLAG_W-1:0] evt_i,
  input  logic                       clr_we_i,
  input  logic [SEL_W-1:0]           clr_sel_i,
  input  flags_t                     clr_bits_i,
  input  logic [NUM_SOCK-1:0]        rearm_i,
  output logic [NUM_SOCK*FLAG_W-1:0] status_o
);
  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    flags_t clr_s, set_s, flags_q;
    assign clr_s = (clr_we_i && clr_sel_i == SEL_W'(s)) ? clr_bits_i : '0;
    assign set_s = evt_i[s*FLAG_W +: FLAG_W] | recv_only(rearm_i[s]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flag_merge(flags_q, set_s, clr_s);
    end
    assign status_o[s*FLAG_W +: FLAG_W] = flags_q;

    // R3: an event never loses against a simultaneous clear
    p_evt_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((flags_q & $past(evt_i[s*FLAG_W +: FLAG_W]))
                        == $past(evt_i[s*FLAG_W +: FLAG_W])));
    // R4: a cleared bit with no set source reads zero
    p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((flags_q & $past(clr_s) & ~$past(set_s)) == '0));
  end
endmodule

// File: rtl/sock_irq_rxchk.sv
module sock_irq_rxchk #(
  parameter int NUM_SOCK = 4,
  parameter int OCC_W    = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SOCK-1:0]       rx_done_i,
  input  logic [NUM_SOCK*OCC_W-1:0] rx_occ_i,
  output logic [NUM_SOCK-1:0]       rearm_o
);
  logic [NUM_SOCK-1:0] done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= '0;
    else        done_q <= rx_done_i;
  end

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_chk
    assign rearm_o[s] = done_q[s] && (rx_occ_i[s*OCC_W +: OCC_W] != '0);

    // R5: a re-raise only follows a receive-complete command
    p_rearm_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && rearm_o[s]) |-> $past(rx_done_i[s]));
  end
endmodule

// File: rtl/sock_irq_pend.sv
module sock_irq_pend #(
  parameter int PEND_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_hit_i,
  input  logic [PEND_W-1:0] pend_i,
  output logic              hold_o
);
  logic [PEND_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr_hit_i)   cnt_q <= pend_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
  assign hold_o = (cnt_q != '0);

  // R6: a clearing write with a nonzero interval starts a release
  p_release_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clr_hit_i) && $past(pend_i) != '0) |-> hold_o);
  // R6: the interval counts down by one per cycle unless reloaded
  p_countdown_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hold_o) && !$past(clr_hit_i))
      |-> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sock_irq_ctrl.sv
module sock_irq_ctrl
  import sock_irq_pkg::*;
#(
  parameter int NUM_SOCK = 4,
  parameter int OCC_W    = 11,
  parameter int PEND_W   = 16,
  localparam int SEL_W   = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1,
  localparam int STAT_W  = NUM_SOCK * FLAG_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [STAT_W-1:0]         evt_i,
  input  logic                      clr_we_i,
  input  logic [SEL_W-1:0]          clr_sel_i,
  input  logic [FLAG_W-1:0]         clr_bits_i,
  input  logic [STAT_W-1:0]         mask_i,
  input  logic [NUM_SOCK-1:0]       rx_done_i,
  input  logic [NUM_SOCK*OCC_W-1:0] rx_occ_i,
  input  logic [PEND_W-1:0]         pend_i,
  output logic [STAT_W-1:0]         status_o,
  output logic                      irq_n_o
);
  // Named internal events
  logic [NUM_SOCK-1:0] rearm;
  logic                clr_hit;
  logic                hold;
  logic                pending;

  assign clr_hit = clr_we_i && (clr_bits_i != '0);

  sock_irq_rxchk #(.NUM_SOCK(NUM_SOCK), .OCC_W(OCC_W)) u_rxchk (
    .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done_i), .rx_occ_i(rx_occ_i),
    .rearm_o(rearm));

  sock_irq_status #(.NUM_SOCK(NUM_SOCK), .SEL_W(SEL_W)) u_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_we_i(clr_we_i),
    .clr_sel_i(clr_sel_i), .clr_bits_i(clr_bits_i), .rearm_i(rearm),
    .status_o(status_o));

  sock_irq_pend #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr_hit_i(clr_hit), .pend_i(pend_i),
    .hold_o(hold));

  assign pending = |(status_o & mask_i);
  assign irq_n_o = ~(pending & ~hold);

  // R8: with nothing enabled and set, the line stays released
  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> irq_n_o);
  // R7: a zero interval never releases a still-pending line
  p_no_release_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clr_hit) && $past(pend_i) == '0 && pending)
      |-> !irq_n_o);

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_rx_sva
    // R5: a re-raise always lands in the receive flag
    p_rearm_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(rearm[s])) |-> status_o[s*FLAG_W + F_RECV]);
  end
endmodule

// File: tb/tb_sock_irq_ctrl.sv
module tb_sock_irq_ctrl;
  localparam int NS = 4;
  localparam int OW = 11;
  localparam int PW = 16;
  localparam int SW = NS * 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [SW-1:0] evt = '0;
  logic          clr_we = 1'b0;
  logic [1:0]    clr_sel = '0;
  logic [4:0]    clr_bits = '0;
  logic [SW-1:0] mask = '1;
  logic [NS-1:0] rx_done = '0;
  logic [NS*OW-1:0] rx_occ = '0;
  logic [PW-1:0] pend = 16'd6;
  logic [SW-1:0] status;
  logic          irq_n;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sock_irq_ctrl #(.NUM_SOCK(NS), .OCC_W(OW), .PEND_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_we_i(clr_we),
    .clr_sel_i(clr_sel), .clr_bits_i(clr_bits), .mask_i(mask),
    .rx_done_i(rx_done), .rx_occ_i(rx_occ), .pend_i(pend),
    .status_o(status), .irq_n_o(irq_n));

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // flag index: socket s, flag f -> 5s+f
  function automatic int fidx(input int s, input int f);
    return s * 5 + f;
  endfunction

  task automatic pulse_evt(input int bitn);
    evt[bitn] = 1'b1;
    tick();
    evt = '0;
  endtask

  task automatic clear_write(input int s, input logic [4:0] bits);
    clr_we = 1'b1; clr_sel = 2'(s); clr_bits = bits;
    tick();
    clr_we = 1'b0; clr_bits = '0;
  endtask

  task automatic t_reset();
    check("R1 status", 32'(status), 32'd0);
    check("R1 irq_n", 32'(irq_n), 32'd1);
  endtask

  task automatic t_event();
    pulse_evt(fidx(1, 0));
    check("R2 connect flag", 32'(status), 32'd1 << fidx(1, 0));
    check("R2 irq_n low", 32'(irq_n), 32'd0);
  endtask

  task automatic t_collide();
    evt[fidx(1, 0)] = 1'b1;
    clear_write(1, 5'b00001);
    evt = '0;
    check("R3 kept on collision", 32'(status[fidx(1, 0)]), 32'd1);
    check("R6 released", 32'(irq_n), 32'd1);
    for (int i = 0; i < 5; i++) tick();
    check("R6 still released at end", 32'(irq_n), 32'd1);
    tick();
    check("R7 reasserted", 32'(irq_n), 32'd0);
  endtask

  task automatic t_zero_write();
    clear_write(1, 5'b00000);
    check("R4 zero write keeps flag", 32'(status[fidx(1, 0)]), 32'd1);
    check("R4 zero write no release", 32'(irq_n), 32'd0);
    clear_write(1, 5'b00001);
    check("R4 one clears", 32'(status), 32'd0);
    check("R4 irq_n idle", 32'(irq_n), 32'd1);
    for (int i = 0; i < 8; i++) tick();
    check("R7 no pending stays high", 32'(irq_n), 32'd1);
  endtask

  task automatic t_rx_recheck();
    int rb;
    rb = fidx(2, 2);
    pulse_evt(rb);
    check("R2 receive flag", 32'(status[rb]), 32'd1);
    rx_occ[2*OW +: OW] = 11'd10;
    clear_write(2, 5'b00100);
    check("R4 receive cleared", 32'(status[rb]), 32'd0);
    rx_done[2] = 1'b1;
    tick();
    rx_done = '0;
    check("R5 not yet raised", 32'(status[rb]), 32'd0);
    tick();
    check("R5 raised with data left", 32'(status[rb]), 32'd1);
    rx_occ[2*OW +: OW] = '0;
    clear_write(2, 5'b00100);
    rx_done[2] = 1'b1;
    tick();
    rx_done = '0;
    tick();
    tick();
    check("R5 empty buffer no raise", 32'(status), 32'd0);
    for (int i = 0; i < 8; i++) tick();
  endtask

  task automatic t_mask();
    int tb3;
    tb3 = fidx(3, 3);
    mask = '1;
    mask[tb3] = 1'b0;
    pulse_evt(tb3);
    check("R8 masked flag visible", 32'(status[tb3]), 32'd1);
    check("R8 masked no irq", 32'(irq_n), 32'd1);
    mask = '1;
    tick();
    check("R8 unmasked drives irq", 32'(irq_n), 32'd0);
  endtask

  task automatic t_pend_zero();
    pend = '0;
    pulse_evt(fidx(0, 0));
    clear_write(0, 5'b00001);
    check("R4 socket0 cleared", 32'(status[fidx(0, 0)]), 32'd0);
    check("R7 zero interval no release", 32'(irq_n), 32'd0);
    pend = 16'd6;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_event();
    t_collide();
    t_zero_write();
    t_rx_recheck();
    t_mask();
    t_pend_zero();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule